// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block sits between two parallel buses, called A and B, and moves data across them in either direction. Each direction has a storage register, an output enable and a select. The select decides whether the output bus carries the live value of the opposite bus or the stored copy. The two enables have opposite polarity. The register of each bus captures that bus when its load strobe is high at a clock edge, whatever the enables and selects are doing.

Each bus is split into an input value, an output value and a per-bit output-enable vector, so the block stays synthesizable. A wrapper at the pad ring can turn each bus into tri-state drivers. The value seen on a bus is the block's own drive when that side is enabled, and the input pins otherwise. This has two effects. A register can capture the value that the block itself places on a bus, which stores one bus into both registers. When both sides are enabled in real-time mode, each bus keeps its last value.

Top module: `rbx_transceiver`

## Requirements
- R1: `b_oe` is all ones exactly when `oe_ab` is 1, and `a_oe` is all ones exactly when `oe_ba_n` is 0. A disabled output value is all zeros.
- R2: `sel_ab` sets the source for B and `sel_ba` sets the source for A. The value 0 picks the opposite bus live: the input of the other bus, or that bus's own drive when it is enabled. The value 1 picks the stored register of the opposite bus.
- R3: At a clock edge with `ld_a` high, the A register takes the A-bus value, and with `ld_b` high the B register takes the B-bus value. The bus value is the block's drive when that side is enabled and the input pins otherwise. The enables and selects have no effect on loading. With its strobe low, a register holds its value.
- R4: With `oe_ab`=0 and `oe_ba_n`=1, neither bus is driven and both registers can still capture their inputs.
- R5: With `oe_ab`=1 and `sel_ab`=1, B carries the A register. With `oe_ba_n`=0 and `sel_ba`=1, A carries the B register. Both transfers can be active together.
- R6: While B carries the stored A value, loading the B register copies the A register into it. The mirror case works the same way in the other direction.
- R7: If both registers are loaded at the same edge while both sides drive stored data, each register takes the old value of the other, so the two registers swap. Filling both registers with one value therefore needs two separate loads.
- R8: With both enabled and both selects 0 (loop mode), each bus keeps the value it had in the cycle before loop mode began. The input pins have no effect, and a load stores that held value.
- R9: Changing a select while the stored and live values are equal leaves the output unchanged.
- R10: An active-low asynchronous reset clears both registers and the held bus values to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe_ab | input | 1 | Drive enable for bus B, active high |
| oe_ba_n | input | 1 | Drive enable for bus A, active low |
| sel_ab | input | 1 | Source for B: 0 live, 1 stored A |
| sel_ba | input | 1 | Source for A: 0 live, 1 stored B |
| ld_a | input | 1 | Load strobe of the A register |
| ld_b | input | 1 | Load strobe of the B register |
| a_in | input | W | Value on bus A pins |
| a_out | output | W | Value driven onto bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value on bus B pins |
| b_out | output | W | Value driven onto bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
Some rules are checked on every cycle:
- enable polarity and the zero value of a disabled output;
- stored data reaching each bus;
- a register holding while its strobe is low, and capturing its inputs while isolated;
- both buses staying still across consecutive loop-mode cycles.

Other behaviour needs a sequence of steps, so only the bench's scenarios show it. This covers storing one bus into both registers, the swap when both registers load at the same edge, and inputs being ignored in loop mode. It also covers toggling a select with equal data, and the sweep of all 64 control combinations against a reference model.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
    typedef enum logic [1:0] {
        SRC_OFF    = 2'd0,
        SRC_LIVE   = 2'd1,
        SRC_STORED = 2'd2,
        SRC_HOLD   = 2'd3
    } src_e;
endpackage

// File: rtl/rbx_dir_mux.sv
module rbx_dir_mux
    import rbx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         en,
    input  logic         sel,
    input  logic         loop,
    input  logic [W-1:0] hold,
    input  logic [W-1:0] stored_fwd,
    input  logic [W-1:0] stored_back,
    input  logic         far_en,
    input  logic [W-1:0] far_in,
    output logic [W-1:0] drv,
    output logic [W-1:0] out
);
    src_e src;

    always_comb begin
        if (loop)      src = SRC_HOLD;
        else if (sel)  src = SRC_STORED;
        else           src = SRC_LIVE;
        case (src)
            SRC_HOLD:   drv = hold;
            SRC_STORED: drv = stored_fwd;
            SRC_LIVE:   drv = far_en ? stored_back : far_in;
            default:    drv = '0;
        endcase
        out = en ? drv : '0;
    end
endmodule

// File: rtl/rbx_transceiver.sv
module rbx_transceiver
    import rbx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         ld_a,
    input  logic         ld_b,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    typedef struct packed {
        logic [W-1:0] reg_a;
        logic [W-1:0] reg_b;
        logic [W-1:0] last_a;
        logic [W-1:0] last_b;
    } state_t;

    state_t st_d, st_q;
    logic         a_en, b_en, loop;
    logic [W-1:0] a_drv, b_drv, a_eff, b_eff;
    logic [W-1:0] reg_a_q, reg_b_q;

    assign a_en    = ~oe_ba_n;
    assign b_en    = oe_ab;
    assign loop    = a_en & b_en & ~sel_ab & ~sel_ba;
    assign reg_a_q = st_q.reg_a;
    assign reg_b_q = st_q.reg_b;

    rbx_dir_mux #(.W(W)) u_mux_a (
        .en(a_en), .sel(sel_ba), .loop(loop), .hold(st_q.last_a),
        .stored_fwd(st_q.reg_b), .stored_back(st_q.reg_a),
        .far_en(b_en), .far_in(b_in), .drv(a_drv), .out(a_out)
    );

    rbx_dir_mux #(.W(W)) u_mux_b (
        .en(b_en), .sel(sel_ab), .loop(loop), .hold(st_q.last_b),
        .stored_fwd(st_q.reg_a), .stored_back(st_q.reg_b),
        .far_en(a_en), .far_in(a_in), .drv(b_drv), .out(b_out)
    );

    assign a_oe  = {W{a_en}};
    assign b_oe  = {W{b_en}};
    assign a_eff = a_en ? a_drv : a_in;
    assign b_eff = b_en ? b_drv : b_in;

    always_comb begin
        st_d = st_q;
        if (ld_a) st_d.reg_a = a_eff;
        if (ld_b) st_d.reg_b = b_eff;
        if (!loop) begin
            st_d.last_a = a_eff;
            st_d.last_b = b_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rbx_transceiver_chk.sv
module rbx_transceiver_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic         ld_a,
    input logic         ld_b,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe,
    input logic [W-1:0] reg_a_q,
    input logic [W-1:0] reg_b_q
);
    logic loop_c;
    assign loop_c = oe_ab & ~oe_ba_n & ~sel_ab & ~sel_ba;

    assert_oe_polarity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe == {W{~oe_ba_n}}) && (b_oe == {W{oe_ab}}));

    assert_off_is_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab |-> b_out == '0) and (oe_ba_n |-> a_out == '0));

    assert_stored_to_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_ab && sel_ab) |-> b_out == reg_a_q);

    assert_stored_to_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ba_n && sel_ba) |-> a_out == reg_b_q);

    assert_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_a |=> $stable(reg_a_q));

    assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_b |=> $stable(reg_b_q));

    assert_iso_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ab && oe_ba_n && ld_a && ld_b) |=>
            (reg_a_q == $past(a_in)) && (reg_b_q == $past(b_in)));

    assert_loop_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_c && $past(loop_c)) |-> ($stable(a_out) && $stable(b_out)));
endmodule

bind rbx_transceiver rbx_transceiver_chk #(.W(W)) u_chk (.*);

// File: tb/test_rbx_transceiver.sv
module test_rbx_transceiver;
    localparam int W = 8;
    localparam int NROW = 6;
    // row: oe_ab oe_ba_n sel_ab sel_ba ld_a ld_b | a_in b_in | exp a_out b_out | exp a_en b_en
    typedef struct packed {
        logic [5:0] ctl;
        logic [7:0] ai, bi, ea, eb;
        logic [1:0] een;
    } row_t;
    localparam row_t TBL [NROW] = '{
        '{6'b010011, 8'h3C, 8'hA5, 8'h00, 8'h00, 2'b00},  // isolate, load both (R4)
        '{6'b101100, 8'hFF, 8'hFF, 8'hA5, 8'h3C, 2'b11},  // both stored (R5)
        '{6'b110000, 8'h5A, 8'h00, 8'h00, 8'h5A, 2'b01},  // live A->B (R2)
        '{6'b000000, 8'h00, 8'hC3, 8'hC3, 8'h00, 2'b10},  // live B->A (R2)
        '{6'b111001, 8'h11, 8'h22, 8'h00, 8'h3C, 2'b01},  // A into B reg (R6)
        '{6'b000100, 8'h00, 8'h00, 8'h3C, 8'h00, 2'b10}   // stored B->A (R6)
    };

    logic clk = 0, rst_n = 0;
    logic oe_ab, oe_ba_n, sel_ab, sel_ba, ld_a, ld_b;
    logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
    int checks = 0, fails = 0;
    logic [W-1:0] m_ra = 0, m_rb = 0, m_la = 0, m_lb = 0;

    always #10 clk = ~clk;

    rbx_transceiver #(.W(W)) i_rbx_transceiver (.*);

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [5:0] c, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        {oe_ab, oe_ba_n, sel_ab, sel_ba, ld_a, ld_b} = c;
        a_in = a; b_in = b;
        #5;
    endtask

    // reference model built from R1..R8
    function automatic void model(output logic [W-1:0] ea, output logic [W-1:0] eb,
                                  output logic ae, output logic be, output logic lp);
        logic [W-1:0] da, db;
        ae = !oe_ba_n; be = oe_ab;
        lp = ae && be && !sel_ab && !sel_ba;
        da = lp ? m_la : sel_ba ? m_rb : (be ? m_ra : b_in);
        db = lp ? m_lb : sel_ab ? m_ra : (ae ? m_rb : a_in);
        ea = ae ? da : '0;
        eb = be ? db : '0;
    endfunction

    task automatic compare_and_clock(string req);
        logic [W-1:0] ea, eb, va, vb;
        logic ae, be, lp;
        model(ea, eb, ae, be, lp);
        check({req, " a_out"}, a_out, ea);
        check({req, " b_out"}, b_out, eb);
        check({req, " a_oe"}, a_oe, {W{ae}});
        check({req, " b_oe"}, b_oe, {W{be}});
        va = ae ? ea : a_in;
        vb = be ? eb : b_in;
        @(posedge clk);
        if (ld_a) m_ra = va;
        if (ld_b) m_rb = vb;
        if (!lp) begin m_la = va; m_lb = vb; end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        {oe_ab, oe_ba_n, sel_ab, sel_ba, ld_a, ld_b} = 6'b101111;
        a_in = 8'h99; b_in = 8'h66;
        repeat (2) @(posedge clk);
        #5;
        // R10: registers cleared, stored transfers show zero
        check("R10 a_out", a_out, 8'h00);
        check("R10 b_out", b_out, 8'h00);
        @(negedge clk);
        {ld_a, ld_b} = 2'b00;
        rst_n = 1;

        // table walk
        for (int i = 0; i < NROW; i++) begin
            drive(TBL[i].ctl, TBL[i].ai, TBL[i].bi);
            check("R1 R2 R5 R6 table a_out", a_out, TBL[i].ea);
            check("R1 R2 R5 R6 table b_out", b_out, TBL[i].eb);
            check("R1 table a_oe", a_oe, {W{TBL[i].een[1]}});
            check("R1 table b_oe", b_oe, {W{TBL[i].een[0]}});
            compare_and_clock("R3 table");
        end

        // all 64 control combinations with random data
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 64; c++) begin
                drive(c[5:0], W'($urandom), W'($urandom));
                compare_and_clock("R2 R3 sweep");
            end
        end

        // R7: simultaneous load with both stored paths swaps the registers
        drive(6'b010011, 8'h12, 8'h34); compare_and_clock("R4 preload");
        drive(6'b101111, 8'h00, 8'h00); compare_and_clock("R7 swap");
        drive(6'b101100, 8'h00, 8'h00);
        check("R7 A reg took old B", b_out, 8'h34);
        check("R7 B reg took old A", a_out, 8'h12);
        compare_and_clock("R7 after");

        // R8: loop mode holds last values, ignores inputs, loads held value
        drive(6'b110000, 8'h77, 8'h00); compare_and_clock("R8 setup");
        drive(6'b100000, 8'hAA, 8'h55);
        check("R8 loop a_out", a_out, 8'h77);
        check("R8 loop b_out", b_out, 8'h77);
        compare_and_clock("R8 loop");
        drive(6'b100010, 8'h01, 8'h02);
        check("R8 loop ignores input", a_out, 8'h77);
        compare_and_clock("R8 loop load");
        drive(6'b101100, 8'h00, 8'h00);
        check("R8 A reg holds looped value", b_out, 8'h77);
        compare_and_clock("R8 verify");

        // R9: toggling select with equal stored and live data
        drive(6'b111000, 8'h77, 8'h00);
        check("R9 stored", b_out, 8'h77);
        sel_ab = 0; #1;
        check("R9 after toggle to live", b_out, 8'h77);
        sel_ab = 1; #1;
        check("R9 after toggle to stored", b_out, 8'h77);
        compare_and_clock("R9 end");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule